// File: doc/BRIEF.md
# Packed Word Media ALU

This block is a single-stage 128-bit SIMD integer arithmetic unit. Each cycle it takes two 128-bit operands, `opA` and `opB`, together with a 3-bit operation select and an input strobe. One clock later it presents a registered 128-bit result with a matching output strobe. Its operation set is aimed at media kernels:

- horizontal pairwise add and subtract on 16-bit words, each with an optional signed clamp;
- a rounded, scaled high multiply on signed words;
- a byte permute steered by a control vector;
- a per-byte sign transfer.

A core issues one operation per cycle with the input strobe high. It may hold the strobe low to leave the previous result in place. The result register and the output strobe are cleared by a synchronous reset.

Top module: `media_word_alu`

## Requirements
- R1: With select 0 (pairwise add), output word k for k in 0..3 is opA word 2k plus opA word 2k+1. Output word k for k in 4..7 is opB word 2(k-4) plus opB word 2(k-4)+1. Sums wrap modulo 2^16. Word k occupies bits [16k+15:16k].
- R2: With select 2 (pairwise subtract), the word pairs are the same as in R1, but each output is the even-numbered word minus the odd-numbered word, wrapping modulo 2^16.
- R3: Selects 1 and 3 are the clamped forms of selects 0 and 2. Each 16-bit result is limited to the signed range -32768..32767 (0x8000..0x7FFF).
- R4: With select 4, each word lane forms the signed 32-bit product of the opA and opB words. It arithmetic-shifts that product right by 14, adds 1, and outputs bits [16:1] of the sum. For 0x8000 times 0x8000 the output is therefore 0x8000.
- R5: With select 5 (byte permute), output byte i is zero whenever bit 7 of opB byte i is set.
- R6: With select 5 and bit 7 of opB byte i clear, output byte i is the opA byte whose number equals bits [3:0] of opB byte i. Bits [6:4] are ignored.
- R7: With select 6 (sign transfer), output byte i depends on opB byte i read as signed. If it is negative, the output is the two's-complement negation of opA byte i. If it is zero, the output is zero. If it is positive, the output is opA byte i unchanged. Negating 0x80 gives 0x80.
- R8: Select 7 produces an all-zero result.
- R9: `outValid` equals `inValid` of the previous clock. While `inValid` is low, the result keeps its value.
- R10: Reset clears `result` and `outValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation strobe |
| opSel | input | 3 | Operation select (encoding in R1 to R8) |
| opA | input | 128 | First operand (element source for permute and sign transfer) |
| opB | input | 128 | Second operand (control for permute and sign transfer) |
| outValid | output | 1 | Result strobe, one clock after inValid |
| result | output | 128 | Registered result |

## Verification
Two things can coincide at a single clock edge: loading a fresh result, and the end of a valid pulse, after which the register must hold. The stimulus toggles the input strobe randomly, so back-to-back operations, isolated operations and idle gaps all appear. At every falling edge the bench compares the result either with a newly computed model value or with the value that should have been held. Directed edge cases sit in the same stream: clamp limits, the 0x8000 squared product, 0x80 negation and zeroed permute lanes.

// File: rtl/media_alu_pkg.sv
package media_alu_pkg;

  typedef enum logic [2:0] {
    OP_HADD  = 3'd0,
    OP_HADDS = 3'd1,
    OP_HSUB  = 3'd2,
    OP_HSUBS = 3'd3,
    OP_MULRS = 3'd4,
    OP_SHUF  = 3'd5,
    OP_SIGN  = 3'd6,
    OP_NONE  = 3'd7
  } op_e;

  typedef struct packed {
    logic load;
    logic horiz;
    logic sub;
    logic sat;
    logic mul;
    logic shuf;
    logic sign;
  } strobe_t;

endpackage

// File: rtl/media_alu_ctrl.sv
module media_alu_ctrl
  import media_alu_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  input  logic [2:0] opSel,
  output strobe_t st,
  output logic    outValid
);

  op_e opCode;
  assign opCode = op_e'(opSel);

  always_comb begin
    st = '0;
    st.load = inValid;
    unique case (opCode)
      OP_HADD:  st.horiz = 1'b1;
      OP_HADDS: begin st.horiz = 1'b1; st.sat = 1'b1; end
      OP_HSUB:  begin st.horiz = 1'b1; st.sub = 1'b1; end
      OP_HSUBS: begin st.horiz = 1'b1; st.sub = 1'b1; st.sat = 1'b1; end
      OP_MULRS: st.mul = 1'b1;
      OP_SHUF:  st.shuf = 1'b1;
      OP_SIGN:  st.sign = 1'b1;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R9: strobe follows input by one clock
  p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  // R8: at most one result source selected
  p_one_sel_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st.horiz, st.mul, st.shuf, st.sign}));

endmodule

// File: rtl/media_alu_dpath.sv
module media_alu_dpath
  import media_alu_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);

  localparam int NW   = DATA_W / 16;
  localparam int NB   = DATA_W / 8;
  localparam int HALF = NW / 2;
  localparam int IDXW = $clog2(NB);

  logic [DATA_W-1:0] horizRes, mulRes, shufRes, signRes, nextRes;

  for (genvar k = 0; k < NW; k++) begin : g_word
    localparam int P = (k < HALF) ? 2 * k : 2 * (k - HALF);
    logic [DATA_W-1:0] srcVec;
    logic [15:0] loW, hiW;
    logic signed [16:0] wide;
    logic signed [31:0] prod;
    logic [16:0] rounded;

    assign srcVec = (k < HALF) ? opA : opB;
    assign loW = srcVec[P*16 +: 16];
    assign hiW = srcVec[(P+1)*16 +: 16];

    always_comb begin
      if (st.sub) wide = $signed({loW[15], loW}) - $signed({hiW[15], hiW});
      else        wide = $signed({loW[15], loW}) + $signed({hiW[15], hiW});
    end

    assign horizRes[k*16 +: 16] = (st.sat && (wide[16] != wide[15])) ?
                                  (wide[16] ? 16'h8000 : 16'h7fff) : wide[15:0];

    assign prod    = $signed(opA[k*16 +: 16]) * $signed(opB[k*16 +: 16]);
    assign rounded = prod[30:14] + 17'd1;
    assign mulRes[k*16 +: 16] = rounded[16:1];
  end

  for (genvar j = 0; j < NB; j++) begin : g_byte
    logic [7:0] ctl, aByte, picked;
    assign ctl    = opB[j*8 +: 8];
    assign aByte  = opA[j*8 +: 8];
    assign picked = opA[ctl[IDXW-1:0]*8 +: 8];
    assign shufRes[j*8 +: 8] = ctl[7] ? 8'h00 : picked;
    assign signRes[j*8 +: 8] = ctl[7] ? (8'h00 - aByte) :
                               ((ctl == 8'h00) ? 8'h00 : aByte);
  end

  always_comb begin
    nextRes = '0;
    if (st.horiz)     nextRes = horizRes;
    else if (st.mul)  nextRes = mulRes;
    else if (st.shuf) nextRes = shufRes;
    else if (st.sign) nextRes = signRes;
  end

  always_ff @(posedge clk) begin
    if (rst)          result <= '0;
    else if (st.load) result <= nextRes;
  end

  // R9: hold while no load
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !st.load |=> $stable(result));
  // R5: control bit 7 zeroes the lane
  p_shuf_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (st.load && st.shuf && opB[7]) |=> (result[7:0] == 8'h00));
  // R7: zero control byte gives zero
  p_sign_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (st.load && st.sign && opB[7:0] == 8'h00) |=> (result[7:0] == 8'h00));
  // R8: no source selected loads zero
  p_opnone_r8: assert property (@(posedge clk) disable iff (rst)
    (st.load && !(st.horiz || st.mul || st.shuf || st.sign)) |=> (result == '0));

endmodule

// File: rtl/media_word_alu.sv
module media_word_alu
  import media_alu_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [2:0]        opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              outValid,
  output logic [DATA_W-1:0] result
);

  strobe_t st;

  media_alu_ctrl i_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .st(st), .outValid(outValid)
  );

  media_alu_dpath #(.DATA_W(DATA_W)) i_dpath (
    .clk(clk), .rst(rst), .st(st), .opA(opA), .opB(opB), .result(result)
  );

endmodule

// File: tb/test_media_word_alu.sv
`timescale 1ns/1ps
module test_media_word_alu;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [2:0] opSel = '0;
  logic [127:0] opA = '0, opB = '0;
  logic outValid;
  logic [127:0] result;

  int checkCnt = 0;
  int failCnt = 0;
  logic [127:0] expRes = '0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  media_word_alu i_media_word_alu (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .opA(opA), .opB(opB), .outValid(outValid), .result(result)
  );

  function automatic logic [127:0] refModel(input int op, input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r = '0;
    if (op <= 3) begin
      for (int w = 0; w < 8; w++) begin
        logic [127:0] s = (w < 4) ? a : b;
        int p = (w % 4) * 2;
        int lo = int'($signed(s[p*16 +: 16]));
        int hi = int'($signed(s[(p+1)*16 +: 16]));
        int v = (op >= 2) ? lo - hi : lo + hi;
        if (op == 1 || op == 3) begin
          if (v > 32767) v = 32767;
          if (v < -32768) v = -32768;
        end
        r[w*16 +: 16] = v[15:0];
      end
    end else if (op == 4) begin
      for (int w = 0; w < 8; w++) begin
        int pr = int'($signed(a[w*16 +: 16])) * int'($signed(b[w*16 +: 16]));
        int t = (pr >>> 14) + 1;
        r[w*16 +: 16] = t[16:1];
      end
    end else if (op == 5) begin
      for (int j = 0; j < 16; j++) begin
        logic [7:0] c = b[j*8 +: 8];
        r[j*8 +: 8] = c[7] ? 8'h00 : a[c[3:0]*8 +: 8];
      end
    end else if (op == 6) begin
      for (int j = 0; j < 16; j++) begin
        int c = int'($signed(b[j*8 +: 8]));
        logic [7:0] x = a[j*8 +: 8];
        r[j*8 +: 8] = (c < 0) ? 8'h00 - x : ((c == 0) ? 8'h00 : x);
      end
    end
    return r;
  endfunction

  function automatic string tagOf(input int op);
    case (op)
      0: return "R1";
      1: return "R3";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checkCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic doOp(input logic v, input int op, input logic [127:0] a, input logic [127:0] b, input string tagOverride);
    string t;
    inValid = v; opSel = op[2:0]; opA = a; opB = b;
    @(negedge clk);
    if (v) expRes = refModel(op, a, b);
    t = (tagOverride != "") ? tagOverride : (v ? tagOf(op) : "R9");
    check("R9", {127'd0, outValid}, {127'd0, v});
    check(t, result, expRes);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      failCnt++;
      checkCnt++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", {outValid, result}, '0);
    rst = 1'b0;

    // R1: wrap 0x7fff + 1
    doOp(1, 0, {112'd0, 16'h0001, 16'h7fff}, {112'd0, 16'hffff, 16'h0003}, "R1");
    // R3: clamp positive
    doOp(1, 1, {112'd0, 16'h0001, 16'h7fff}, {96'd0, 16'h8000, 16'hffff}, "R3");
    // R2: 0x8000 - 1 wraps
    doOp(1, 2, {112'd0, 16'h0001, 16'h8000}, '0, "R2");
    // R3: clamp negative
    doOp(1, 3, {112'd0, 16'h0001, 16'h8000}, {112'd0, 16'h8000, 16'h7fff}, "R3");
    // R4: 0x8000 squared
    doOp(1, 4, {8{16'h8000}}, {8{16'h8000}}, "R4");
    doOp(1, 4, {8{16'h4000}}, {8{16'hc000}}, "R4");
    // R5: bit 7 zeroes lanes
    doOp(1, 5, rnd128(), {16{8'h83}}, "R5");
    // R6: reversal with ignored bits [6:4]
    doOp(1, 5, 128'h0f0e0d0c0b0a09080706050403020100,
         128'h70615243342516070879fa6b5c4d3e2f & 128'h7f7f7f7f7f7f7f7f7f7f7f7f7f7f7f7f, "R6");
    // R7: -128 wraps, zero, positive
    doOp(1, 6, {16{8'h80}}, {16{8'hff}}, "R7");
    doOp(1, 6, {16{8'h11}}, {{8{8'h00}}, {8{8'h05}}}, "R7");
    // R8: select 7
    doOp(1, 7, rnd128(), rnd128(), "R8");
    // R9: hold while idle
    doOp(0, 0, rnd128(), rnd128(), "R9");
    doOp(0, 4, rnd128(), rnd128(), "R9");

    for (int n = 0; n < 600; n++) begin
      logic v = ($urandom % 10) < 6;
      int op = $urandom % 8;
      logic [127:0] a = rnd128();
      logic [127:0] b = rnd128();
      if (op == 5 && ($urandom % 2)) b = b & {16{8'h0f}};
      if (op == 6 && ($urandom % 2)) b = b & {8{16'h00ff}};
      doOp(v, op, a, b, "");
    end

    // R10: mid-run reset
    doOp(1, 0, rnd128(), rnd128(), "");
    rst = 1'b1; inValid = 1'b1;
    @(negedge clk);
    check("R10", {outValid, result}, '0);
    rst = 1'b0; inValid = 1'b0;
    expRes = '0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule